// File: doc/BRIEF.md
# Holdover Frequency Averager

This block sits beside the loop filter of a digital PLL and keeps a slowly moving average of the loop's frequency control word. While the loop is locked, every valid frequency sample pulls the average toward itself by a programmable fraction, a power of two. When the loop falls into holdover, the block stops learning. It drives the frozen average to the numerically controlled oscillator, so the output keeps the last well-filtered frequency and does not follow any reference.

A three-bit mode code selects the command source. Free-run and reserved codes command zero offset. The tracking codes (locked, both pre-lock variants and lost-phase) pass the latest valid sample straight through. Holdover replays the average. A read-average control chooses whether a registered readback port shows the average or the latest sample. A sticky flag reports when enough locked samples have been absorbed for the average to be meaningful.

Top module: `ho_freq_avg`

## Requirements
- R1: While rst_ni is low, and after it is released, nco_cmd_o, rdbk_o and hist_valid_o are 0, and the average and latest-sample registers are 0.
- R2: With mode_i = 2 (locked) and freq_vld_i = 1 at a clock edge, the average becomes avg + ((freq_i - avg) >>> shift_i) at that edge. The subtraction is exact, the shift is arithmetic (rounds toward minus infinity), and the result is kept to 40 bits.
- R3: The average does not change at an edge where mode_i is not 2 or freq_vld_i is 0.
- R4: With mode_i = 5 (holdover), nco_cmd_o equals the stored average combinationally, in the same cycle the code appears. It stays constant while the mode remains 5, whatever freq_i and freq_vld_i do.
- R5: With mode_i = 0 (free-run), or a reserved code 6 or 7, nco_cmd_o is 0.
- R6: The latest-sample register loads freq_i at every edge with freq_vld_i = 1, in any mode. With mode_i in {1, 2, 3, 4}, nco_cmd_o equals that register.
- R7: rdbk_o is registered. At each edge it loads the average if rd_avg_i = 1, and the latest-sample register if rd_avg_i = 0, using the values held just before that edge.
- R8: hist_valid_o rises at the edge that absorbs the 2^shift_i-th locked valid sample since reset. Valid samples in other modes are not counted. The flag then stays high until reset.
- R9: With shift_i = 0, a locked valid sample is copied into the average unchanged.
- R10: The new average always lies between the old average and the sample, inclusive, for any signed 40-bit inputs, including full-scale values of opposite sign, with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Loop mode: 0 free-run, 1 pre-lock, 2 locked, 3 pre-lock 2, 4 lost-phase, 5 holdover, 6-7 reserved |
| freq_i | input | 40 | Signed instantaneous frequency word |
| freq_vld_i | input | 1 | freq_i holds a new sample |
| rd_avg_i | input | 1 | Readback source: 1 average, 0 latest sample |
| shift_i | input | 5 | Averaging shift (filter weight 2^-shift_i) |
| nco_cmd_o | output | 40 | Signed frequency command to the oscillator |
| rdbk_o | output | 40 | Registered readback value |
| hist_valid_o | output | 1 | Average has absorbed at least 2^shift_i locked samples |

## Verification
Four properties are checked on every cycle: the average holds still outside locked valid updates, each update lands between the old average and the sample, a zero shift copies the sample, and the history flag is sticky and rises only on an update. The same holds for the holdover command staying constant for as long as holdover lasts and for free-run forcing zero. The exact arithmetic values only show up in the bench's scenarios, including floor rounding of negative steps and full-scale opposite-sign samples. So do the same-cycle switch into holdover, the readback source choice and its one-cycle latency, and the exact sample count that raises the history flag.

// File: rtl/ho_avg_pkg.sv
package ho_avg_pkg;
  typedef logic [2:0] mode_t;

  localparam mode_t MODE_FREE = 3'd0;
  localparam mode_t MODE_PRE1 = 3'd1;
  localparam mode_t MODE_LOCK = 3'd2;
  localparam mode_t MODE_PRE2 = 3'd3;
  localparam mode_t MODE_LOST = 3'd4;
  localparam mode_t MODE_HOLD = 3'd5;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_LIVE = 2'd1,
    SEL_AVG  = 2'd2
  } cmd_sel_e;

  function automatic cmd_sel_e decode_mode(mode_t m);
    case (m)
      MODE_PRE1, MODE_LOCK, MODE_PRE2, MODE_LOST: decode_mode = SEL_LIVE;
      MODE_HOLD:                                   decode_mode = SEL_AVG;
      default:                                     decode_mode = SEL_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/ho_iir_core.sv
module ho_iir_core #(
  parameter int W       = 40,
  parameter int SHIFT_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_i,
  input  logic signed [W-1:0] sample_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  output logic signed [W-1:0] avg_o,
  output logic                hist_o
);
  localparam int CNT_W = (1 << SHIFT_W) + 1;

  logic signed [W-1:0] avg_q;
  logic signed [W:0]   diff;
  logic signed [W:0]   step;
  logic signed [W:0]   nxt;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    cnt_inc;
  logic [CNT_W-1:0]    thresh;
  logic                hist_q;

  // one guard bit keeps the difference exact
  always_comb begin
    diff = {sample_i[W-1], sample_i} - {avg_q[W-1], avg_q};
    step = diff >>> shift_i;
    nxt  = {avg_q[W-1], avg_q} + step;
  end

  assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
  assign thresh  = CNT_W'(1) << shift_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avg_q  <= '0;
      cnt_q  <= '0;
      hist_q <= 1'b0;
    end else if (upd_i) begin
      avg_q  <= nxt[W-1:0];
      cnt_q  <= cnt_inc;
      hist_q <= hist_q | (cnt_inc >= thresh);
    end
  end

  assign avg_o  = avg_q;
  assign hist_o = hist_q;

  AST_AVG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(avg_q)); // R3

  AST_AVG_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (($past(avg_q) <= $past(sample_i))
               ? (avg_q >= $past(avg_q) && avg_q <= $past(sample_i))
               : (avg_q <= $past(avg_q) && avg_q >= $past(sample_i)))); // R10

  AST_SHIFT0_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && shift_i == '0) |=> avg_q == $past(sample_i)); // R9

  AST_HIST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_q |=> hist_q); // R8

  AST_HIST_NEEDS_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hist_q) |-> $past(upd_i)); // R8
endmodule

// File: rtl/ho_live_rdbk.sv
module ho_live_rdbk #(
  parameter int W = 40
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic signed [W-1:0] freq_i,
  input  logic                rd_avg_i,
  input  logic signed [W-1:0] avg_i,
  output logic signed [W-1:0] live_o,
  output logic signed [W-1:0] rdbk_o
);
  logic signed [W-1:0] live_q;
  logic signed [W-1:0] rdbk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      rdbk_q <= '0;
    end else begin
      if (vld_i) live_q <= freq_i;
      rdbk_q <= rd_avg_i ? avg_i : live_q;
    end
  end

  assign live_o = live_q;
  assign rdbk_o = rdbk_q;

  AST_LIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(live_q)); // R6

  AST_RDBK_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_avg_i && !vld_i) ##1 !rd_avg_i |=> rdbk_q == $past(rdbk_q)); // R7
endmodule

// File: rtl/ho_cmd_sel.sv
module ho_cmd_sel
  import ho_avg_pkg::*;
#(
  parameter int W = 40
) (
  input  mode_t               mode_i,
  input  logic signed [W-1:0] live_i,
  input  logic signed [W-1:0] avg_i,
  output logic signed [W-1:0] cmd_o
);
  cmd_sel_e sel;

  always_comb begin
    sel = decode_mode(mode_i);
    unique case (sel)
      SEL_LIVE: cmd_o = live_i;
      SEL_AVG:  cmd_o = avg_i;
      default:  cmd_o = '0;
    endcase
  end
endmodule

// File: rtl/ho_freq_avg.sv
module ho_freq_avg
  import ho_avg_pkg::*;
#(
  parameter int W       = 40,
  parameter int SHIFT_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          mode_i,
  input  logic signed [W-1:0] freq_i,
  input  logic                freq_vld_i,
  input  logic                rd_avg_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  output logic signed [W-1:0] nco_cmd_o,
  output logic signed [W-1:0] rdbk_o,
  output logic                hist_valid_o
);
  logic                upd;
  logic signed [W-1:0] avg;
  logic signed [W-1:0] live;

  assign upd = (mode_i == MODE_LOCK) && freq_vld_i;

  ho_iir_core #(.W(W), .SHIFT_W(SHIFT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd),
    .sample_i (freq_i),
    .shift_i  (shift_i),
    .avg_o    (avg),
    .hist_o   (hist_valid_o)
  );

  ho_live_rdbk #(.W(W)) u_rdbk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (freq_vld_i),
    .freq_i   (freq_i),
    .rd_avg_i (rd_avg_i),
    .avg_i    (avg),
    .live_o   (live),
    .rdbk_o   (rdbk_o)
  );

  ho_cmd_sel #(.W(W)) u_sel (
    .mode_i (mode_i),
    .live_i (live),
    .avg_i  (avg),
    .cmd_o  (nco_cmd_o)
  );

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HOLD && $past(mode_i) == MODE_HOLD) |-> $stable(nco_cmd_o)); // R4

  AST_FREE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FREE || mode_i > MODE_HOLD) |-> nco_cmd_o == '0); // R5
endmodule

// File: tb/ho_freq_avg_tb.sv
module ho_freq_avg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 40;

  typedef struct packed {
    logic [2:0]          mode;
    logic                vld;
    logic signed [W-1:0] freq;
    logic                rd;
    logic signed [W-1:0] exp_rd;
    logic signed [W-1:0] exp_cmd;
    logic                exp_hist;
  } vec_t;

  // shift_i = 2, starting from reset
  localparam vec_t VECS [11] = '{
    '{3'd2, 1'b1,  40'sd400,  1'b1, 40'sd100,  40'sd400,  1'b0}, // R2 R6
    '{3'd2, 1'b1,  40'sd400,  1'b1, 40'sd175,  40'sd400,  1'b0}, // R2
    '{3'd2, 1'b1,  40'sd400,  1'b0, 40'sd400,  40'sd400,  1'b0}, // R2 R7 live
    '{3'd2, 1'b1, -40'sd400,  1'b1, 40'sd73,  -40'sd400,  1'b1}, // R2 floor, R8
    '{3'd5, 1'b1,  40'sd1000, 1'b1, 40'sd73,   40'sd73,   1'b1}, // R3 R4
    '{3'd5, 1'b0,  40'sd5,    1'b0, 40'sd1000, 40'sd73,   1'b1}, // R4 R7
    '{3'd1, 1'b1, -40'sd8,    1'b1, 40'sd73,  -40'sd8,    1'b1}, // R3 R6
    '{3'd0, 1'b0,  40'sd0,    1'b0, -40'sd8,   40'sd0,    1'b1}, // R5
    '{3'd4, 1'b1,  40'sd16,   1'b0, 40'sd16,   40'sd16,   1'b1}, // R6
    '{3'd7, 1'b0,  40'sd0,    1'b1, 40'sd73,   40'sd0,    1'b1}, // R5 R3
    '{3'd2, 1'b1,  40'sd73,   1'b1, 40'sd73,   40'sd73,   1'b1}  // R2 zero step
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [2:0]          mode = 3'd0;
  logic signed [W-1:0] freq = '0;
  logic                vld = 1'b0;
  logic                rd = 1'b0;
  logic [4:0]          shift = 5'd2;
  logic signed [W-1:0] nco_cmd;
  logic signed [W-1:0] rdbk;
  logic                hist;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ho_freq_avg dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_i       (mode),
    .freq_i       (freq),
    .freq_vld_i   (vld),
    .rd_avg_i     (rd),
    .shift_i      (shift),
    .nco_cmd_o    (nco_cmd),
    .rdbk_o       (rdbk),
    .hist_valid_o (hist)
  );

  task automatic chk(input string req, input logic signed [W-1:0] act,
                     input logic signed [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    vld = 1'b0;
    #1;
    chk("R1 cmd in reset", nco_cmd, '0);
    chk("R1 rdbk in reset", rdbk, '0);
    chk("R1 hist in reset", W'(hist), '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // sample edge, then a quiet edge that loads the readback
  task automatic step(input logic [2:0] m, input logic v,
                      input logic signed [W-1:0] f, input logic r);
    @(negedge clk);
    mode = m; vld = v; freq = f; rd = r;
    @(negedge clk);
    vld = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    mode = 3'd2; freq = 40'sd999; vld = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 cmd in reset", nco_cmd, '0);
    chk("R1 hist in reset", W'(hist), '0);
    vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdbk after reset", rdbk, '0);

    foreach (VECS[i]) begin
      step(VECS[i].mode, VECS[i].vld, VECS[i].freq, VECS[i].rd);
      chk($sformatf("R7 vec %0d rdbk", i), rdbk, VECS[i].exp_rd);
      chk($sformatf("R6 vec %0d cmd", i), nco_cmd, VECS[i].exp_cmd);
      chk($sformatf("R8 vec %0d hist", i), W'(hist), W'(VECS[i].exp_hist));
    end

    // R4: same-cycle switch to holdover; avg 73 -> 273, live 873
    step(3'd2, 1'b1, 40'sd873, 1'b1);
    chk("R2 avg before holdover", rdbk, 40'sd273);
    chk("R6 locked cmd is live", nco_cmd, 40'sd873);
    mode = 3'd5;
    #1;
    chk("R4 holdover same cycle", nco_cmd, 40'sd273);
    freq = 40'sd5000; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    @(negedge clk);
    chk("R4 holdover stays frozen", nco_cmd, 40'sd273);

    // R9: shift 0 copies the sample
    shift = 5'd0;
    step(3'd2, 1'b1, -40'sd12345, 1'b1);
    chk("R9 shift0 copy", rdbk, -40'sd12345);

    // R10: full-scale opposite signs, shift 1
    do_reset();
    shift = 5'd1;
    step(3'd2, 1'b1, 40'sh7F_FFFF_FFFF, 1'b1);
    chk("R10 max positive", rdbk, 40'sh3F_FFFF_FFFF);
    step(3'd2, 1'b1, 40'sh80_0000_0000, 1'b1);
    chk("R10 min negative", rdbk, 40'shDF_FFFF_FFFF);

    // R8: shift 3 needs 8 locked samples; non-locked ones do not count
    do_reset();
    shift = 5'd3;
    rd = 1'b1;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); mode = 3'd2; vld = 1'b1; freq = 40'sd64;
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); mode = 3'd5; vld = 1'b1; freq = 40'sd64;
    end
    @(negedge clk);
    vld = 1'b0;
    chk("R8 hist after 7 locked", W'(hist), '0);
    mode = 3'd2; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    chk("R8 hist after 8 locked", W'(hist), 40'sd1);
    mode = 3'd0;
    repeat (3) @(negedge clk);
    chk("R8 hist sticky", W'(hist), 40'sd1);
    chk("R5 free-run zero", nco_cmd, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule